// File: doc/BRIEF.md
# Full-Bridge Gate Commutation Controller

This block drives the four gate enables of an H-bridge: high-left, high-right, low-left and low-right. A priority decoder turns three level inputs into one of three states. The states are bridge off, start-up (both low-side switches on) and oscillation. In the oscillation state the block alternates between the two diagonal pairs of the bridge. Every change of pair passes through a non-overlap interval in which all four gates are off.

The pair is chosen from a bridge clock in one of two ways. In direct mode the pair follows the clock level. In halving mode the clock is divided by two, and the pair changes only on falling clock edges. Halving mode always starts from a fixed diagonal.

The non-overlap interval is adaptive. It ends when a comparator reports that the falling slope of the half-bridge node just switched off has finished. It is never shorter than a fixed minimum. If the comparator never reports, a timeout ends the interval. The bridge clock and both slope flags pass through synchronisers before use.

Top module: `hbridge_commutator`

## Requirements
- R1: While `bridge_off_i` is 1, all four gate outputs are 0, regardless of every other input.
- R2: With `bridge_off_i`=0 and `run_en_i`=0, `gate_ll_o` and `gate_lr_o` are 1 and both high-side outputs are 0.
- R3: In oscillation (`bridge_off_i`=0, `run_en_i`=1) with `direct_i`=1, a high `bclk_i` selects pair A (high-left plus low-right on) and a low `bclk_i` selects pair B (high-right plus low-left on).
- R4: With `direct_i`=0 the pair toggles once per 1-to-0 transition of `bclk_i`; a 0-to-1 transition changes nothing.
- R5: Each entry into oscillation with `direct_i`=0 starts with pair A conducting.
- R6: On every change of pair, all four outputs go to 0 first. In oscillation, the outputs only ever show pair A, pair B, or all off.
- R7: The all-off interval lasts at least MIN_DEAD cycles. It ends on the slope flag of the leg that was switched off: `slope_left_i` when leaving pair A, `slope_right_i` when leaving pair B. The new pair appears three clock edges after that flag rises; the other flag has no effect.
- R8: If the relevant slope flag stays 0, the all-off interval ends after exactly MAX_DEAD cycles.
- R9: A pair change requested during an all-off interval is served after that interval ends, and the high-side and low-side outputs of one leg are never 1 together.
- R10: Leaving oscillation through `bridge_off_i` or `run_en_i` changes the outputs in the same cycle, even in mid-interval. It also clears the halving phase, so the next entry starts from pair A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_off_i | input | 1 | Forces all gates off, highest priority |
| run_en_i | input | 1 | 0 holds the start-up state, 1 allows oscillation |
| direct_i | input | 1 | 1 makes the pair follow the clock level, 0 halves the clock |
| bclk_i | input | 1 | Bridge clock, asynchronous |
| slope_left_i | input | 1 | Left node falling slope finished, asynchronous |
| slope_right_i | input | 1 | Right node falling slope finished, asynchronous |
| gate_hl_o | output | 1 | High-left gate enable |
| gate_hr_o | output | 1 | High-right gate enable |
| gate_ll_o | output | 1 | Low-left gate enable |
| gate_lr_o | output | 1 | Low-right gate enable |

## Verification
The bench measures the exact length of the all-off interval in three cases: with the flag already high, with the flag never arriving, and with the flag arriving late after the wrong flag was raised. A miscounted minimum, a swapped flag selection or an off-by-one timeout each show up as a wrong cycle count. It toggles the clock back during an interval and expects the pending pair to conduct before the bridge returns. A design that dropped the request would stay on the first pair. It leaves and re-enters oscillation in mid-interval and after pair B. A design that kept the halving phase would come back on pair B, and one that waited for the interval would lag by at least one cycle.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
   typedef enum logic {
      DIAG_A = 1'b0,   // high-left + low-right
      DIAG_B = 1'b1    // high-right + low-left
   } diag_e;

   typedef struct packed {
      logic hl;
      logic hr;
      logic ll;
      logic lr;
   } gates_t;

   localparam gates_t GATES_OFF  = '{hl: 1'b0, hr: 1'b0, ll: 1'b0, lr: 1'b0};
   localparam gates_t GATES_LOWS = '{hl: 1'b0, hr: 1'b0, ll: 1'b1, lr: 1'b1};

   function automatic gates_t diag_gates(diag_e d);
      gates_t g;
      g.hl = (d == DIAG_A);
      g.lr = (d == DIAG_A);
      g.hr = (d == DIAG_B);
      g.ll = (d == DIAG_B);
      return g;
   endfunction
endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= {st[STAGES-2:0], d};
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/hbc_phase.sv
module hbc_phase
   import hbc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  osc,
   input  logic  direct,
   input  logic  bclk_s,
   output diag_e want
);
   logic  bclk_d;
   diag_e ph;
   logic  fall;

   assign fall = bclk_d & ~bclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d <= 1'b0;
         ph     <= DIAG_A;
      end else begin
         bclk_d <= bclk_s;
         if (!osc)                 ph <= DIAG_A;
         else if (!direct && fall) ph <= diag_e'(~ph);
      end
   end

   // direct: clock high selects A, low selects B
   assign want = direct ? diag_e'(~bclk_s) : ph;
endmodule

// File: rtl/hbc_deadtime.sv
module hbc_deadtime
   import hbc_pkg::*;
#(
   parameter int MIN_DEAD = 4,
   parameter int MAX_DEAD = 40
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  osc,
   input  diag_e want,
   input  diag_e entry,
   input  logic  slope_l,
   input  logic  slope_r,
   output diag_e cur,
   output logic  dead
);
   localparam int CW = $clog2(MAX_DEAD + 1);

   if (MIN_DEAD < 1 || MAX_DEAD <= MIN_DEAD) begin : g_bad_dead
      $error("hbc_deadtime: need 1 <= MIN_DEAD < MAX_DEAD");
   end

   logic [CW-1:0] cnt;
   logic          slope_sel, min_ok, tmo, done;

   // leaving A switches off high-left: the left node falls
   assign slope_sel = (cur == DIAG_A) ? slope_l : slope_r;
   assign min_ok    = (cnt >= CW'(MIN_DEAD - 1));
   assign tmo       = (cnt >= CW'(MAX_DEAD - 1));
   assign done      = (min_ok && slope_sel) || tmo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur  <= DIAG_A;
         dead <= 1'b0;
         cnt  <= '0;
      end else if (!osc) begin
         cur  <= entry;
         dead <= 1'b0;
         cnt  <= '0;
      end else if (dead) begin
         if (done) begin
            dead <= 1'b0;
            cur  <= diag_e'(~cur);
            cnt  <= '0;
         end else begin
            cnt  <= cnt + 1'b1;
         end
      end else if (want != cur) begin
         dead <= 1'b1;
         cnt  <= '0;
      end
   end
endmodule

// File: rtl/hbridge_commutator.sv
module hbridge_commutator
   import hbc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_DEAD    = 4,
   parameter int MAX_DEAD    = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bridge_off_i,
   input  logic run_en_i,
   input  logic direct_i,
   input  logic bclk_i,
   input  logic slope_left_i,
   input  logic slope_right_i,
   output logic gate_hl_o,
   output logic gate_hr_o,
   output logic gate_ll_o,
   output logic gate_lr_o
);
   logic [2:0] raw_s;
   logic       osc, dead;
   diag_e      want, cur, entry;
   gates_t     g;

   hbc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({bclk_i, slope_left_i, slope_right_i}),
      .q    (raw_s)
   );

   assign osc   = ~bridge_off_i & run_en_i;
   assign entry = direct_i ? diag_e'(~raw_s[2]) : DIAG_A;

   hbc_phase u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .osc   (osc),
      .direct(direct_i),
      .bclk_s(raw_s[2]),
      .want  (want)
   );

   hbc_deadtime #(.MIN_DEAD(MIN_DEAD), .MAX_DEAD(MAX_DEAD)) u_dead (
      .clk    (clk),
      .rst_n  (rst_n),
      .osc    (osc),
      .want   (want),
      .entry  (entry),
      .slope_l(raw_s[1]),
      .slope_r(raw_s[0]),
      .cur    (cur),
      .dead   (dead)
   );

   // state priority: off, then start-up, then oscillation
   always_comb begin
      if (bridge_off_i)  g = GATES_OFF;
      else if (!run_en_i) g = GATES_LOWS;
      else if (dead)     g = GATES_OFF;
      else               g = diag_gates(cur);
   end

   assign gate_hl_o = g.hl;
   assign gate_hr_o = g.hr;
   assign gate_ll_o = g.ll;
   assign gate_lr_o = g.lr;
endmodule

// File: rtl/hbridge_commutator_chk.sv
module hbridge_commutator_chk #(
   parameter int MIN_DEAD = 4,
   parameter int MAX_DEAD = 40
) (
   input logic clk,
   input logic rst_n,
   input logic off,
   input logic run,
   input logic hl,
   input logic hr,
   input logic ll,
   input logic lr
);
   logic        osc, all_off;
   logic [15:0] offcnt;

   assign osc     = ~off & run;
   assign all_off = ~(hl | hr | ll | lr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     offcnt <= '0;
      else if (osc && all_off)        offcnt <= (offcnt == 16'hFFFF) ? offcnt : offcnt + 1'b1;
      else                            offcnt <= '0;
   end

   p_off_forces_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      off |-> all_off);

   p_startup_lows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!off && !run) |-> (ll && lr && !hl && !hr));

   p_valid_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (osc && !all_off) |-> ((hl && lr && !hr && !ll) || (hr && ll && !hl && !lr)));

   p_leg_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hl && ll) && !(hr && lr));

   p_dead_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (osc && $past(osc) && $past(all_off) && !all_off) |-> (offcnt >= 16'(MIN_DEAD)));

   p_dead_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
      osc |-> (offcnt <= 16'(MAX_DEAD)));
endmodule

bind hbridge_commutator hbridge_commutator_chk #(.MIN_DEAD(MIN_DEAD), .MAX_DEAD(MAX_DEAD)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .off  (bridge_off_i),
   .run  (run_en_i),
   .hl   (gate_hl_o),
   .hr   (gate_hr_o),
   .ll   (gate_ll_o),
   .lr   (gate_lr_o)
);

// File: tb/hbridge_commutator_test.sv
`timescale 1ns/1ps
module hbridge_commutator_test;
   localparam int MIN_D = 4;
   localparam int MAX_D = 40;
   localparam logic [3:0] G_OFF  = 4'b0000;
   localparam logic [3:0] G_LOWS = 4'b0011;
   localparam logic [3:0] G_A    = 4'b1001;  // {hl,hr,ll,lr}
   localparam logic [3:0] G_B    = 4'b0110;

   logic clk = 1'b0, rst_n = 1'b0;
   logic boff = 1'b1, run = 1'b0, direct = 1'b0, bclk = 1'b0, sl = 1'b0, sr = 1'b0;
   logic hl, hr, ll, lr;
   wire  [3:0] g = {hl, hr, ll, lr};
   int   total = 0, bad = 0, cycles = 0;
   logic overlap_seen = 1'b0;

   always #2.5 clk = ~clk;

   hbridge_commutator #(.SYNC_STAGES(2), .MIN_DEAD(MIN_D), .MAX_DEAD(MAX_D)) uut (
      .clk(clk), .rst_n(rst_n), .bridge_off_i(boff), .run_en_i(run), .direct_i(direct),
      .bclk_i(bclk), .slope_left_i(sl), .slope_right_i(sr),
      .gate_hl_o(hl), .gate_hr_o(hr), .gate_ll_o(ll), .gate_lr_o(lr)
   );

   always @(negedge clk) begin
      cycles++;
      if (rst_n && ((hl && ll) || (hr && lr))) overlap_seen = 1'b1;
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog act=%0d exp<=100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic chk_n(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // wait for all-off, count its samples, return the first non-off value
   task automatic measure_off(output int n, output logic [3:0] after);
      int guard = 0;
      n = 0;
      while (g != G_OFF && guard < 200) begin tick(1); guard++; end
      while (g == G_OFF && n < 500) begin n++; tick(1); end
      after = g;
   endtask

   task automatic t_reset_and_off();
      chk("R1 reset", g, G_OFF);
      rst_n = 1'b1;
      run = 1'b1; direct = 1'b1; bclk = 1'b1; sl = 1'b1; sr = 1'b1;
      tick(6);
      chk("R1 off with run+direct+clock high", g, G_OFF);
      direct = 1'b0; bclk = 1'b0;
      tick(6);
      chk("R1 off in halving mode", g, G_OFF);
   endtask

   task automatic t_startup();
      boff = 1'b0; run = 1'b0;
      tick(1);
      chk("R2 start-up lows", g, G_LOWS);
      bclk = 1'b1; tick(5); bclk = 1'b0; tick(5);
      chk("R2 lows ignore clock", g, G_LOWS);
   endtask

   task automatic t_halving();
      int n; logic [3:0] aft;
      direct = 1'b0; bclk = 1'b0; sl = 1'b1; sr = 1'b1;
      run = 1'b1;
      tick(1);
      chk("R5 first pair is A", g, G_A);
      bclk = 1'b1; tick(8);
      chk("R4 rising edge keeps A", g, G_A);
      bclk = 1'b0;
      measure_off(n, aft);
      chk_n("R7 minimum non-overlap", n, MIN_D);
      chk("R4 falling edge gives B", aft, G_B);
      sl = 1'b0; sr = 1'b0;
      bclk = 1'b1; tick(8);
      chk("R4 rising edge keeps B", g, G_B);
      bclk = 1'b0;
      measure_off(n, aft);
      chk_n("R8 timeout non-overlap", n, MAX_D);
      chk("R8 A after timeout", aft, G_A);
   endtask

   task automatic t_late_flag();
      int guard = 0;
      bclk = 1'b1; tick(8);
      bclk = 1'b0;
      while (g != G_OFF && guard < 50) begin tick(1); guard++; end
      tick(10);
      sr = 1'b1;   // wrong leg for leaving A
      tick(6);
      chk("R7 right flag ignored leaving A", g, G_OFF);
      sl = 1'b1;
      tick(2);
      chk("R7 still off two edges after flag", g, G_OFF);
      tick(1);
      chk("R7 B on third edge after flag", g, G_B);
      sl = 1'b0; sr = 1'b0;
   endtask

   task automatic t_exit();
      int guard = 0;
      run = 1'b0; #0.5;
      chk("R10 immediate exit to lows", g, G_LOWS);
      tick(3);
      run = 1'b1; tick(1);
      chk("R10 re-entry from A", g, G_A);
      bclk = 1'b1; tick(4); bclk = 1'b0;
      while (g != G_OFF && guard < 50) begin tick(1); guard++; end
      tick(3);
      boff = 1'b1; #0.5;
      chk("R10 disable mid-interval", g, G_OFF);
      tick(2);
      boff = 1'b0; tick(1);
      chk("R10 phase cleared after disable", g, G_A);
   endtask

   task automatic t_direct();
      int n; logic [3:0] aft;
      direct = 1'b1; sl = 1'b1; sr = 1'b1;
      bclk = 1'b1; tick(10);
      chk("R3 clock high gives A", g, G_A);
      bclk = 1'b0;
      measure_off(n, aft);
      chk_n("R6 direct mode non-overlap", n, MIN_D);
      chk("R3 clock low gives B", aft, G_B);
      bclk = 1'b1; tick(12);
      chk("R3 clock high back to A", g, G_A);
   endtask

   task automatic t_held();
      int n1 = 0, n2; logic [3:0] aft; int guard = 0;
      sl = 1'b0; sr = 1'b0;
      bclk = 1'b0;
      while (g != G_OFF && guard < 50) begin tick(1); guard++; end
      while (g == G_OFF && n1 < 500) begin
         if (n1 == 5) bclk = 1'b1;   // ask for A again mid-interval
         n1++; tick(1);
      end
      chk_n("R9 first interval length", n1, MAX_D);
      chk("R9 pending pair B served", g, G_B);
      measure_off(n2, aft);
      chk_n("R9 second interval length", n2, MAX_D);
      chk("R9 back to A", aft, G_A);
      chk("R9 no leg overlap seen", {3'b000, overlap_seen}, 4'b0000);
   endtask

   initial begin
      tick(3);
      t_reset_and_off();
      t_startup();
      t_halving();
      t_late_flag();
      t_exit();
      t_direct();
      t_held();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule